// File: doc/BRIEF.md
# Coprocessor Macro-Instruction Dispatcher

This block sits between a host CPU and a vector coprocessor. The host hands it one 32-bit coprocessor instruction at a time. The block decodes the instruction and carries it out against the coprocessor. The outcome is one of four actions:

- a register transfer (a 128-bit vector move or a 32-bit control move, in either direction);
- a microprogram start with a start address;
- a pair of upper/lower micro-instruction words issued to the coprocessor;
- a reserved-instruction exception.

While an instruction is in progress the block holds the host stalled. It waits on the coprocessor's busy, divide-unit busy and interlock-release status according to fixed rules.

Macro-operations are never overlapped. An arithmetic macro-op waits for the coprocessor to be idle before it is issued, and the host stays stalled until the coprocessor is idle again. Each instruction finishes with a single-cycle `done` pulse, or with an `exc` pulse for a reserved encoding. The host presents the next instruction only after that pulse.

The coprocessor register file, its datapath and the host pipeline are outside the block. They appear only as the handshake and data ports below.

Top module: `cop2_dispatch`

## Requirements
- R1: With bits 31..26 = 6'b010010 and bits 25..21 = 1, the block performs a 128-bit read from the coprocessor. `xfer_valid` pulses with `xfer_to_cp`=0 and `xfer_wide`=1, and `xfer_data` equals `cp_rdata`. `xfer_gpr` shows bits 20..16 and `cp_reg_idx` shows bits 15..11 throughout the stall.
- R2: With bits 25..21 = 2 and bits 10..1 all zero, the block performs a 32-bit control read. `xfer_data` is `cp_rdata[31:0]` sign-extended to 64 bits, upper 64 bits zero, with `xfer_wide`=0 and `xfer_to_cp`=0.
- R3: Bits 25..21 = 5 select a 128-bit write to the coprocessor, and `xfer_data` equals `host_rdata`. Bits 25..21 = 6 with bits 10..1 all zero select a 32-bit control write, and `xfer_data` is `host_rdata[31:0]` zero-extended. Both writes have `xfer_to_cp`=1.
- R4: A read with bit 0 set acts in the first cycle in which `cp_busy` is low. With bit 0 clear it acts one cycle after acceptance, whatever `cp_busy` is.
- R5: A write with bit 0 set acts in the first cycle in which `cp_ilock_rel` is high. With bit 0 clear it acts one cycle after acceptance.
- R6: Bits 10..0 = 11'h3BF is a wait for the divide unit. It completes in the first cycle in which `cp_q_busy` is low, and no action pulse is produced.
- R7: Function field bits 5..0 = 6'h38 waits for `cp_busy` low, then pulses `start_valid` with `start_addr` equal to bits 20..6.
- R8: Function field 6'h39 does the same as R7, but `start_addr` is taken from `saved_start`.
- R9: An upper-class operation (function < 6'h30, or function >= 6'h3C with bits 10..6 < 5'h0C) issues upper word 32'h40000000 | bits 24..0 and lower word 32'h8000033C.
- R10: A lower-class operation (function 6'h30..6'h35, or function >= 6'h3C with bits 10..6 >= 5'h0C) issues upper word 32'h400002FF and lower word 32'h10000000 | bits 24..0.
- R11: An upper- or lower-class op issues only once `cp_busy` is low. It then ignores `cp_busy` for one cycle and completes with `done` in the first cycle after that in which `cp_busy` is low.
- R12: Any other encoding, including any encoding whose bits 31..26 differ from 6'b010010, pulses `exc` and produces no `done` and no other action.
- R13: Decode priority runs in this order: transfers, then the divide wait, then the two starts, then the upper class, then the lower class.
- R14: After reset and between instructions, `stall` and all pulses are low. `stall` is high from the cycle after acceptance until the completion pulse, and an `instr_valid` presented while stalled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Host presents an instruction |
| instr | input | 32 | Instruction word |
| host_rdata | input | 128 | Host general register value for writes |
| cp_busy | input | 1 | Coprocessor executing |
| cp_q_busy | input | 1 | Coprocessor divide unit busy |
| cp_ilock_rel | input | 1 | Coprocessor micro-interlock released |
| cp_rdata | input | 128 | Coprocessor register value at `cp_reg_idx` |
| saved_start | input | 15 | Stored microprogram start address |
| stall | output | 1 | Host must hold |
| cp_reg_idx | output | 5 | Coprocessor register index |
| xfer_gpr | output | 5 | Host general register index |
| xfer_valid | output | 1 | Transfer pulse |
| xfer_to_cp | output | 1 | Transfer direction, 1 = into coprocessor |
| xfer_wide | output | 1 | 1 = 128-bit, 0 = 32-bit control |
| xfer_data | output | 128 | Transfer data |
| start_valid | output | 1 | Microprogram start pulse |
| start_addr | output | 15 | Microprogram start address |
| issue_valid | output | 1 | Micro-instruction pair issue pulse |
| issue_upper | output | 32 | Upper micro-instruction word |
| issue_lower | output | 32 | Lower micro-instruction word |
| done | output | 1 | Instruction complete |
| exc | output | 1 | Reserved-instruction exception |

## Verification
Counting edges from the accepting edge, an action (transfer, start, issue or exception) appears one edge after its wait condition first holds. With no wait this is one cycle after acceptance. The coprocessor model in the bench holds `cp_busy` for B cycles and `cp_q_busy` for Q cycles, and raises `cp_ilock_rel` one cycle before busy drops. From these the bench predicts an action cycle of B+1, max(1,B), Q+1 or 1, depending on the rule. For an issued pair, `done` is due N+2 cycles after the issue pulse, where N is the busy time the model applies after issue. The bench samples every output on the falling edge, records the cycle of each pulse, and compares the recorded cycle with the prediction as well as the captured field values.

// File: rtl/cop2_dispatch.sv
module cop2_dispatch (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         instr_valid,
  input  logic [31:0]  instr,
  input  logic [127:0] host_rdata,
  input  logic         cp_busy,
  input  logic         cp_q_busy,
  input  logic         cp_ilock_rel,
  input  logic [127:0] cp_rdata,
  input  logic [14:0]  saved_start,
  output logic         stall,
  output logic [4:0]   cp_reg_idx,
  output logic [4:0]   xfer_gpr,
  output logic         xfer_valid,
  output logic         xfer_to_cp,
  output logic         xfer_wide,
  output logic [127:0] xfer_data,
  output logic         start_valid,
  output logic [14:0]  start_addr,
  output logic         issue_valid,
  output logic [31:0]  issue_upper,
  output logic [31:0]  issue_lower,
  output logic         done,
  output logic         exc
);
  localparam logic [5:0]  OPC_COP2  = 6'b010010;
  localparam logic [31:0] UP_BASE   = 32'h4000_0000;
  localparam logic [31:0] LO_BASE   = 32'h1000_0000;
  localparam logic [31:0] UP_FILL   = 32'h4000_02FF;
  localparam logic [31:0] LO_FILL   = 32'h8000_033C;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ISSUE, S_DRAIN} state_t;
  typedef enum logic [3:0] {K_VRD, K_CRD, K_VWR, K_CWR, K_QWAIT,
                            K_RUN, K_RUNS, K_UP, K_LO, K_RSV} kind_t;

  state_t      st;
  kind_t       kind;
  logic [31:0] ir;
  logic        ready;

  wire [4:0] rs     = ir[25:21];
  wire [5:0] fn     = ir[5:0];
  wire [4:0] sub    = ir[10:6];
  wire       mid_z  = (ir[10:1] == 10'd0);

  assign stall      = (st != S_IDLE);
  assign cp_reg_idx = ir[15:11];
  assign xfer_gpr   = ir[20:16];

  always_comb begin
    kind = K_RSV;
    if (ir[31:26] != OPC_COP2)                      kind = K_RSV;
    else if (rs == 5'd1)                            kind = K_VRD;
    else if (rs == 5'd2 && mid_z)                   kind = K_CRD;
    else if (rs == 5'd5)                            kind = K_VWR;
    else if (rs == 5'd6 && mid_z)                   kind = K_CWR;
    else if (ir[10:0] == 11'h3BF)                   kind = K_QWAIT;
    else if (fn == 6'h38)                           kind = K_RUN;
    else if (fn == 6'h39)                           kind = K_RUNS;
    else if (fn < 6'h30 || (fn >= 6'h3C && sub < 5'h0C))
                                                    kind = K_UP;
    else if ((fn >= 6'h30 && fn <= 6'h35) || fn >= 6'h3C)
                                                    kind = K_LO;
  end

  always_comb begin
    case (kind)
      K_VRD, K_CRD: ready = !ir[0] || !cp_busy;
      K_VWR, K_CWR: ready = !ir[0] || cp_ilock_rel;
      K_QWAIT:      ready = !cp_q_busy;
      K_RSV:        ready = 1'b1;
      default:      ready = !cp_busy;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ir          <= '0;
      xfer_valid  <= 1'b0;
      xfer_to_cp  <= 1'b0;
      xfer_wide   <= 1'b0;
      xfer_data   <= '0;
      start_valid <= 1'b0;
      start_addr  <= '0;
      issue_valid <= 1'b0;
      issue_upper <= '0;
      issue_lower <= '0;
      done        <= 1'b0;
      exc         <= 1'b0;
    end else begin
      xfer_valid  <= 1'b0;
      start_valid <= 1'b0;
      issue_valid <= 1'b0;
      done        <= 1'b0;
      exc         <= 1'b0;
      case (st)
        S_IDLE: if (instr_valid) begin
          ir <= instr;
          st <= S_WAIT;
        end
        S_WAIT: if (ready) begin
          st <= S_IDLE;
          case (kind)
            K_VRD: begin
              xfer_valid <= 1'b1; xfer_to_cp <= 1'b0; xfer_wide <= 1'b1;
              xfer_data <= cp_rdata; done <= 1'b1;
            end
            K_CRD: begin
              xfer_valid <= 1'b1; xfer_to_cp <= 1'b0; xfer_wide <= 1'b0;
              xfer_data <= {64'd0, {32{cp_rdata[31]}}, cp_rdata[31:0]};
              done <= 1'b1;
            end
            K_VWR: begin
              xfer_valid <= 1'b1; xfer_to_cp <= 1'b1; xfer_wide <= 1'b1;
              xfer_data <= host_rdata; done <= 1'b1;
            end
            K_CWR: begin
              xfer_valid <= 1'b1; xfer_to_cp <= 1'b1; xfer_wide <= 1'b0;
              xfer_data <= {96'd0, host_rdata[31:0]}; done <= 1'b1;
            end
            K_QWAIT: done <= 1'b1;
            K_RUN: begin
              start_valid <= 1'b1; start_addr <= ir[20:6]; done <= 1'b1;
            end
            K_RUNS: begin
              start_valid <= 1'b1; start_addr <= saved_start; done <= 1'b1;
            end
            K_UP: begin
              issue_valid <= 1'b1;
              issue_upper <= UP_BASE | {7'd0, ir[24:0]};
              issue_lower <= LO_FILL;
              st <= S_ISSUE;
            end
            K_LO: begin
              issue_valid <= 1'b1;
              issue_upper <= UP_FILL;
              issue_lower <= LO_BASE | {7'd0, ir[24:0]};
              st <= S_ISSUE;
            end
            default: exc <= 1'b1;
          endcase
        end
        S_ISSUE: st <= S_DRAIN;
        default: if (!cp_busy) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  AST_READ_ILOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_to_cp && ir[0]) |-> !$past(cp_busy)); // R4
  AST_WRITE_ILOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_to_cp && ir[0]) |-> $past(cp_ilock_rel)); // R5
  AST_QWAIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && kind == K_QWAIT) |-> !$past(cp_q_busy)); // R6
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> !$past(cp_busy)); // R7
  AST_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !$past(cp_busy)); // R11
  AST_ISSUE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (kind == K_UP || kind == K_LO)) |-> (!$past(cp_busy) && !$past(issue_valid))); // R11
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_valid, start_valid, issue_valid, exc})); // R12
  AST_EXC_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    exc |-> !done); // R12
  AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done || exc) |-> !stall); // R14
endmodule

// File: tb/cop2_dispatch_test.sv
module cop2_dispatch_test;
  localparam int K_VRD = 0, K_CRD = 1, K_VWR = 2, K_CWR = 3, K_QW = 4,
                 K_RUN = 5, K_RUNS = 6, K_UP = 7, K_LO = 8, K_RSV = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [127:0] host_rdata = '0, cp_rdata = '0;
  logic [14:0] saved_start = '0;
  logic cp_busy, cp_q_busy, cp_ilock_rel;
  logic stall, xfer_valid, xfer_to_cp, xfer_wide, start_valid, issue_valid, done, exc;
  logic [4:0] cp_reg_idx, xfer_gpr;
  logic [127:0] xfer_data;
  logic [14:0] start_addr;
  logic [31:0] issue_upper, issue_lower;

  int checks = 0, failures = 0, cycles = 0;
  int busy_cnt = 0, q_cnt = 0, load_b = 0, load_q = 0, issue_len = 0;
  logic load_en = 1'b0;

  always #10 clk = ~clk;

  cop2_dispatch uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .host_rdata(host_rdata), .cp_busy(cp_busy), .cp_q_busy(cp_q_busy),
    .cp_ilock_rel(cp_ilock_rel), .cp_rdata(cp_rdata), .saved_start(saved_start),
    .stall(stall), .cp_reg_idx(cp_reg_idx), .xfer_gpr(xfer_gpr),
    .xfer_valid(xfer_valid), .xfer_to_cp(xfer_to_cp), .xfer_wide(xfer_wide),
    .xfer_data(xfer_data), .start_valid(start_valid), .start_addr(start_addr),
    .issue_valid(issue_valid), .issue_upper(issue_upper), .issue_lower(issue_lower),
    .done(done), .exc(exc));

  assign cp_busy      = (busy_cnt != 0);
  assign cp_q_busy    = (q_cnt != 0);
  assign cp_ilock_rel = (busy_cnt <= 1);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (load_en) begin
      busy_cnt <= load_b;
      q_cnt    <= load_q;
    end else begin
      if (issue_valid) busy_cnt <= issue_len;
      else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
      if (q_cnt > 0) q_cnt <= q_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [31:0] i);
    logic [5:0] f = i[5:0];
    logic [4:0] s = i[10:6];
    logic z = (i[10:1] == 10'd0);
    if (i[31:26] != 6'b010010) return K_RSV;
    if (i[25:21] == 5'd1) return K_VRD;
    if (i[25:21] == 5'd2 && z) return K_CRD;
    if (i[25:21] == 5'd5) return K_VWR;
    if (i[25:21] == 5'd6 && z) return K_CWR;
    if (i[10:0] == 11'h3BF) return K_QW;
    if (f == 6'h38) return K_RUN;
    if (f == 6'h39) return K_RUNS;
    if (f < 6'h30 || (f >= 6'h3C && s < 5'h0C)) return K_UP;
    if ((f >= 6'h30 && f <= 6'h35) || (f >= 6'h3C && s >= 5'h0C)) return K_LO;
    return K_RSV;
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      K_VRD: return "R1"; K_CRD: return "R2"; K_VWR, K_CWR: return "R3";
      K_QW: return "R6"; K_RUN: return "R7"; K_RUNS: return "R8";
      K_UP: return "R9"; K_LO: return "R10"; default: return "R12";
    endcase
  endfunction

  task automatic exec(input logic [31:0] ins, input int b, input int q, input int n);
    int act_k = -1, done_k = -1, exc_k = -1, npulse = 0, exp_act, exp_done, kd;
    logic [127:0] c_data = '0;
    logic c_to = 1'b0, c_wide = 1'b0, c_x = 1'b0, c_s = 1'b0, c_i = 1'b0;
    logic [14:0] c_addr = '0;
    logic [31:0] c_up = '0, c_lo = '0;
    string t, tw;
    kd = kind_of(ins);
    t = tag_of(kd);
    host_rdata  = {$urandom, $urandom, $urandom, $urandom};
    cp_rdata    = {$urandom, $urandom, $urandom, $urandom};
    saved_start = 15'($urandom);
    @(negedge clk);
    instr = ins; instr_valid = 1'b1;
    load_en = 1'b1; load_b = b; load_q = q; issue_len = n;
    @(negedge clk);
    load_en = 1'b0;
    instr = $urandom;
    chk(stall == 1'b1, "R14", "stall after accept", 128'(stall), 1);
    chk(cp_reg_idx == ins[15:11] && xfer_gpr == ins[20:16], "R1", "register indices",
        {cp_reg_idx, xfer_gpr}, {ins[15:11], ins[20:16]});
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      if (xfer_valid || start_valid || issue_valid || exc) begin
        npulse++;
        if (act_k < 0) begin
          act_k = k; c_x = xfer_valid; c_s = start_valid; c_i = issue_valid;
          c_data = xfer_data; c_to = xfer_to_cp; c_wide = xfer_wide;
          c_addr = start_addr; c_up = issue_upper; c_lo = issue_lower;
        end
      end
      if (done) done_k = k;
      if (exc) exc_k = k;
      if (done || exc) begin
        instr_valid = 1'b0;
        break;
      end
    end
    case (kd)
      K_VRD, K_CRD: exp_act = ins[0] ? b + 1 : 1;
      K_VWR, K_CWR: exp_act = ins[0] ? ((b < 1) ? 1 : b) : 1;
      K_QW:         exp_act = q + 1;
      K_RSV:        exp_act = 1;
      default:      exp_act = b + 1;
    endcase
    exp_done = (kd == K_UP || kd == K_LO) ? exp_act + 2 + n : exp_act;
    tw = (kd <= K_CRD) ? "R4" : (kd <= K_CWR) ? "R5" : (kd == K_UP || kd == K_LO) ? "R11" : t;
    if (kd == K_RSV) begin
      chk(exc_k == 1 && done_k < 0 && npulse == 1 && !c_x && !c_s && !c_i,
          "R12", "exception only", 128'(exc_k), 1);
    end else if (kd == K_QW) begin
      chk(done_k == exp_done && npulse == 0, "R6", "q wait completion", 128'(done_k), 128'(exp_done));
    end else begin
      chk(act_k == exp_act && npulse == 1, tw, "action cycle", 128'(act_k), 128'(exp_act));
      chk(done_k == exp_done, tw, "done cycle", 128'(done_k), 128'(exp_done));
      case (kd)
        K_VRD: chk(c_x && !c_to && c_wide && c_data == cp_rdata, t, "vector read", c_data, cp_rdata);
        K_CRD: chk(c_x && !c_to && !c_wide &&
                   c_data == {64'd0, {32{cp_rdata[31]}}, cp_rdata[31:0]}, t, "control read",
                   c_data, {64'd0, {32{cp_rdata[31]}}, cp_rdata[31:0]});
        K_VWR: chk(c_x && c_to && c_wide && c_data == host_rdata, t, "vector write", c_data, host_rdata);
        K_CWR: chk(c_x && c_to && !c_wide && c_data == {96'd0, host_rdata[31:0]}, t,
                   "control write", c_data, {96'd0, host_rdata[31:0]});
        K_RUN: chk(c_s && c_addr == ins[20:6], t, "start address", 128'(c_addr), 128'(ins[20:6]));
        K_RUNS: chk(c_s && c_addr == saved_start, t, "stored start", 128'(c_addr), 128'(saved_start));
        K_UP: chk(c_i && c_up == (32'h40000000 | {7'd0, ins[24:0]}) && c_lo == 32'h8000033C, t,
                  "upper pair", {c_up, c_lo}, {(32'h40000000 | {7'd0, ins[24:0]}), 32'h8000033C});
        default: chk(c_i && c_up == 32'h400002FF && c_lo == (32'h10000000 | {7'd0, ins[24:0]}), t,
                  "lower pair", {c_up, c_lo}, {32'h400002FF, (32'h10000000 | {7'd0, ins[24:0]})});
      endcase
    end
    chk(stall == 1'b0, "R14", "stall released at completion", 128'(stall), 0);
    @(negedge clk);
    chk(!stall && !xfer_valid && !start_valid && !issue_valid && !done && !exc, "R14",
        "stalled-time instruction ignored", {stall, xfer_valid, start_valid, issue_valid, done, exc}, 0);
  endtask

  function automatic logic [31:0] mk(input logic [4:0] rs, input logic [20:0] low);
    return {6'b010010, rs, low};
  endfunction

  function automatic logic [31:0] rand_ins();
    logic [31:0] r = $urandom;
    int sel = $urandom % 11;
    r[31:26] = 6'b010010;
    r[25:21] = 5'h10;
    case (sel)
      0: r[25:21] = 5'd1;
      1: begin r[25:21] = 5'd2; r[10:1] = '0; end
      2: r[25:21] = 5'd5;
      3: begin r[25:21] = 5'd6; r[10:1] = '0; end
      4: r[10:0] = 11'h3BF;
      5: r[5:0] = 6'h38;
      6: r[5:0] = 6'h39;
      7: r[5:0] = 6'($urandom % 48);
      8: r[5:0] = 6'h3C + 6'($urandom % 4);
      9: r[5:0] = 6'h30 + 6'($urandom % 12);
      default: r[31:26] = 6'($urandom);
    endcase
    return r;
  endfunction

  initial begin
    void'($urandom(32'hC0D2));
    repeat (3) @(negedge clk);
    chk(!stall && !xfer_valid && !start_valid && !issue_valid && !done && !exc, "R14",
        "outputs during reset", {stall, xfer_valid, start_valid, issue_valid, done, exc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!stall && !done && !exc, "R14", "reset state", {stall, done, exc}, 0);

    exec(mk(5'd1, {5'd3, 5'd7, 10'd0, 1'b1}), 3, 0, 0);      // R1 R4 interlocked read
    exec(mk(5'd1, {5'd3, 5'd7, 10'd0, 1'b0}), 4, 0, 0);      // R4 no interlock
    cp_rdata = '0;
    exec(mk(5'd2, {5'd1, 5'd2, 10'd0, 1'b0}), 0, 0, 0);      // R2
    exec(mk(5'd6, {5'd4, 5'd9, 10'd0, 1'b1}), 4, 0, 0);      // R3 R5 waits for release
    exec(mk(5'd5, {5'd4, 5'd9, 10'd0, 1'b1}), 0, 0, 0);      // R3 R5
    exec(mk(5'h10, {10'h155, 11'h3BF}), 2, 3, 0);            // R6 R13 over lower class
    exec(mk(5'd1, {15'h1234, 6'h38}), 0, 0, 0);              // R13 transfer over start
    exec(mk(5'h10, {15'h7FFF, 6'h38}), 2, 0, 0);             // R7 max address
    exec(mk(5'h10, {15'h0001, 6'h39}), 1, 0, 0);             // R8
    exec(mk(5'h10, {10'h0, 5'h0B, 6'h3C}), 1, 0, 3);         // R9 boundary
    exec(mk(5'h10, {10'h0, 5'h0C, 6'h3C}), 0, 0, 0);         // R10 boundary
    exec(mk(5'h10, {10'h3FF, 5'h1F, 6'h2F}), 2, 0, 4);       // R9 R11
    exec(mk(5'h10, {10'h2AA, 5'h05, 6'h35}), 0, 0, 2);       // R10 R11
    exec(mk(5'h10, {10'h0, 5'h00, 6'h36}), 0, 0, 0);         // R12
    exec(mk(5'd6, {10'h0, 5'h01, 6'h3A}), 0, 0, 0);          // R12 bits 10..1 nonzero
    exec({6'b010011, 26'h0000_020}, 0, 0, 0);                // R12 wrong opcode

    for (int i = 0; i < 300; i++)
      exec(rand_ins(), $urandom % 5, $urandom % 5, $urandom % 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule